// File: doc/BRIEF.md
# Flash Converter Digital Back End

This block is the digital half of an 8-bit parallel (flash) analog-to-digital converter. The analog comparator bank sits outside it and delivers one bit per comparator as a thermometer vector. The block follows the converter clock through its two half-cycles: a balance half, in which the comparators zero themselves, and a sample half, in which they track the input. It captures the comparator vector as each sample half ends and reduces it to a binary code plus an overflow flag. A short register pipeline then carries the result to three-state output pins.

The converter clock `cnv_clk` reaches the block as a level that the system clock `clk` samples. Every half-cycle is therefore a whole number of `clk` periods. A select input, `half_sel`, decides which level of `cnv_clk` counts as the sample half. A three-state control process tracks the halves in these states: `HS_IDLE` after reset, `HS_BALANCE` and `HS_SAMPLE`. Its transitions are:
- IDLE→BALANCE, on the first balance level.
- BALANCE→SAMPLE, named the balance end.
- SAMPLE→BALANCE, named the sample end.

Every other combination holds the current state.

Two enables gate the outputs. An active-low enable covers all nine output pins. An active-high enable additionally covers the eight code pins, so the overflow pin can be driven while the code pins float.

Top module: `flash_backend`

## Requirements
- R1: `thermo_i` carries 256 comparator bits. Bits 0 to 254 (comparators 1 to 255) alone form the code. Bit 255 (comparator 256) alone forms the overflow flag, so a vector with only bit 255 set yields code 0 with overflow 1.
- R2: `cnv_clk` is in its sample half when it equals `half_sel` and in its balance half otherwise. With `half_sel` low, the low level samples; with `half_sel` high, the roles swap.
- R3: the comparator vector is captured on the `clk` edge at which `cnv_clk` is first seen at the balance level after a sample half. Changes to `thermo_i` during the balance half have no effect on any later output.
- R4: the vector captured at the end of sample N is encoded at the following balance end. It reaches the outputs on the `clk` edge that ends sample N+1, and from then on it is visible for the whole balance half that follows.
- R5: the code equals the number of asserted bits among bits 0 to 254, clamped to 255. An isolated gap or stray bit in the thermometer therefore shifts the code by at most the count of such bits and never by a whole segment.
- R6: an all-zero vector yields code 0 with overflow 0. An all-ones vector (input above the top reference) yields code 255 with overflow 1.
- R7: while `oe_all_n` is high, all nine outputs are high impedance.
- R8: while `oe_all_n` is low and `oe_data` is low, the eight code outputs are high impedance and `ovf_o` still drives the overflow flag.
- R9: a synchronous reset clears every pipeline stage, so the outputs read code 0 with overflow 0, and returns the control to idle. A sample level present at reset release is not captured until a balance half has been seen.
- R10: between two sample ends the outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| half_sel | input | 1 | Selects which `cnv_clk` level is the sample half |
| cnv_clk | input | 1 | Converter clock level, sampled by `clk` |
| thermo_i | input | 256 | Comparator outputs, bit 0 = lowest threshold |
| oe_all_n | input | 1 | Active-low enable for all nine outputs |
| oe_data | input | 1 | Active-high enable for the eight code outputs |
| data_o | output | 8 | Binary code, three-state |
| ovf_o | output | 1 | Overflow flag, three-state |

## Verification
The result of sample N becomes due one `clk` edge after `cnv_clk` leaves the sample level of sample N+1. The bench drives every input on falling edges and reads the outputs on the falling edge right after that capture edge, expecting the value of the previous sample. It then reads again at each remaining falling edge of the balance half to confirm the value holds. The enable checks are combinational and are taken after a small delay inside a balance half, when no pipeline stage can move. The sweeps are repeated for both `half_sel` values and for half-cycle lengths of one to three `clk` periods, so any miscount of the capture edge shows up as a value from the wrong sample.

// File: rtl/flash_backend_pkg.sv
package flash_backend_pkg;

    // Half-cycle tracking states of the converter clock
    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_BALANCE = 2'd1,
        HS_SAMPLE  = 2'd2
    } half_state_t;

    // Sample half when the converter clock level matches the select input
    function automatic logic is_sample_level(input logic lvl, input logic sel);
        return lvl == sel;
    endfunction

endpackage

// File: rtl/flash_half_fsm.sv
module flash_half_fsm
    import flash_backend_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cnv_clk,
    input  logic        half_sel,
    output half_state_t state_o,
    output logic        sample_end_o,
    output logic        balance_end_o
);

    half_state_t st_q;
    half_state_t st_d;
    logic        in_sample;

    assign in_sample = is_sample_level(cnv_clk, half_sel);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= HS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        unique case (st_q)
            HS_IDLE:    st_d = in_sample ? HS_IDLE   : HS_BALANCE;
            HS_BALANCE: st_d = in_sample ? HS_SAMPLE : HS_BALANCE;
            HS_SAMPLE:  st_d = in_sample ? HS_SAMPLE : HS_BALANCE;
            default:    st_d = HS_IDLE;
        endcase
    end

    // Event outputs: one-cycle strobes on half boundaries
    always_comb begin
        sample_end_o  = 1'b0;
        balance_end_o = 1'b0;
        unique case (st_q)
            HS_IDLE:    ;
            HS_BALANCE: balance_end_o = in_sample;
            HS_SAMPLE:  sample_end_o  = !in_sample;
            default:    ;
        endcase
    end

    assign state_o = st_q;

endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc #(
    parameter int RES_BITS = 8,
    parameter int GROUP    = 16
) (
    input  logic [(1<<RES_BITS)-2:0] therm_i,
    output logic [RES_BITS-1:0]      code_o
);

    localparam int NIN  = (1 << RES_BITS) - 1;
    localparam int NGRP = (NIN + GROUP - 1) / GROUP;
    localparam int PADW = NGRP * GROUP;
    localparam int GW   = $clog2(GROUP + 1);
    localparam int SW   = RES_BITS + 1;
    localparam logic [SW-1:0] MAXC = SW'(NIN);

    logic [PADW-1:0] padded;
    logic [GW-1:0]   part [NGRP];
    logic [SW-1:0]   total;

    assign padded = PADW'(therm_i);

    // Per-group ones count
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GW-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int i = 0; i < GROUP; i++) begin
                cnt = cnt + GW'(padded[g*GROUP + i]);
            end
        end
        assign part[g] = cnt;
    end

    // Sum of group counts, clamped to full scale
    always_comb begin
        total = '0;
        for (int k = 0; k < NGRP; k++) begin
            total = total + SW'(part[k]);
        end
        code_o = (total > MAXC) ? MAXC[RES_BITS-1:0] : total[RES_BITS-1:0];
    end

endmodule

// File: rtl/flash_oe_gate.sv
module flash_oe_gate #(
    parameter int W = 8
) (
    input  logic         oe_all_n,
    input  logic         oe_data,
    input  logic [W-1:0] code_i,
    input  logic         ovf_i,
    output logic [W-1:0] data_o,
    output logic         ovf_o
);

    logic drive_code;
    logic drive_ovf;

    assign drive_ovf  = !oe_all_n;
    assign drive_code = !oe_all_n && oe_data;

    assign data_o = drive_code ? code_i : {W{1'bz}};
    assign ovf_o  = drive_ovf  ? ovf_i  : 1'bz;

endmodule

// File: rtl/flash_backend.sv
module flash_backend
    import flash_backend_pkg::*;
#(
    parameter int RES_BITS  = 8,
    parameter int ENC_GROUP = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     half_sel,
    input  logic                     cnv_clk,
    input  logic [(1<<RES_BITS)-1:0] thermo_i,
    input  logic                     oe_all_n,
    input  logic                     oe_data,
    output logic [RES_BITS-1:0]      data_o,
    output logic                     ovf_o
);

    localparam int NCOMP = 1 << RES_BITS;

    half_state_t         st_w;
    logic                sample_end;
    logic                balance_end;
    logic [NCOMP-1:0]    lat_q;
    logic [RES_BITS-1:0] enc_code;
    logic [RES_BITS-1:0] dec_code_q;
    logic                dec_ovf_q;
    logic [RES_BITS-1:0] out_code_q;
    logic                out_ovf_q;

    flash_half_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cnv_clk       (cnv_clk),
        .half_sel      (half_sel),
        .state_o       (st_w),
        .sample_end_o  (sample_end),
        .balance_end_o (balance_end)
    );

    flash_therm_enc #(
        .RES_BITS (RES_BITS),
        .GROUP    (ENC_GROUP)
    ) u_enc (
        .therm_i (lat_q[NCOMP-2:0]),
        .code_o  (enc_code)
    );

    // Pipeline: comparator latch, decoded stage, output register
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q      <= '0;
            dec_code_q <= '0;
            dec_ovf_q  <= 1'b0;
            out_code_q <= '0;
            out_ovf_q  <= 1'b0;
        end else begin
            if (sample_end) begin
                lat_q      <= thermo_i;
                out_code_q <= dec_code_q;
                out_ovf_q  <= dec_ovf_q;
            end
            if (balance_end) begin
                dec_code_q <= enc_code;
                dec_ovf_q  <= lat_q[NCOMP-1];
            end
        end
    end

    flash_oe_gate #(
        .W (RES_BITS)
    ) u_oe (
        .oe_all_n (oe_all_n),
        .oe_data  (oe_data),
        .code_i   (out_code_q),
        .ovf_i    (out_ovf_q),
        .data_o   (data_o),
        .ovf_o    (ovf_o)
    );

endmodule

// File: rtl/flash_backend_chk.sv
module flash_backend_chk
    import flash_backend_pkg::*;
#(
    parameter int RES_BITS = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cnv_clk,
    input logic                     half_sel,
    input half_state_t              st,
    input logic                     sample_end,
    input logic                     balance_end,
    input logic [(1<<RES_BITS)-1:0] lat_q,
    input logic [RES_BITS-1:0]      dec_code_q,
    input logic                     dec_ovf_q,
    input logic [RES_BITS-1:0]      out_code_q,
    input logic                     out_ovf_q
);

    localparam int NCOMP = 1 << RES_BITS;

    p_halves_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(sample_end && balance_end));

    p_sample_polarity_r2: assert property (@(posedge clk) disable iff (rst)
        (st == HS_SAMPLE) |-> ($past(cnv_clk) == $past(half_sel)));

    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !sample_end |=> $stable(lat_q));

    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !sample_end |=> ($stable(out_code_q) && $stable(out_ovf_q)));

    p_ovf_from_top_r1: assert property (@(posedge clk) disable iff (rst)
        balance_end |=> (dec_ovf_q == $past(lat_q[NCOMP-1])));

    p_full_scale_r6: assert property (@(posedge clk) disable iff (rst)
        (balance_end && (&lat_q[NCOMP-2:0])) |=> (&dec_code_q));

    p_zero_scale_r6: assert property (@(posedge clk) disable iff (rst)
        (balance_end && (lat_q == '0)) |=> ((dec_code_q == '0) && !dec_ovf_q));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> ((out_code_q == '0) && !out_ovf_q && (st == HS_IDLE)));

endmodule

bind flash_backend flash_backend_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnv_clk     (cnv_clk),
    .half_sel    (half_sel),
    .st          (st_w),
    .sample_end  (sample_end),
    .balance_end (balance_end),
    .lat_q       (lat_q),
    .dec_code_q  (dec_code_q),
    .dec_ovf_q   (dec_ovf_q),
    .out_code_q  (out_code_q),
    .out_ovf_q   (out_ovf_q)
);

// File: tb/flash_backend_test.sv
module flash_backend_test;

    localparam int NC = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          half_sel = 1'b0;
    logic          cnv_clk = 1'b0;
    logic [NC-1:0] thermo_i = '0;
    logic          oe_all_n = 1'b0;
    logic          oe_data = 1'b1;
    wire  [7:0]    data_o;
    wire           ovf_o;

    int   n_run = 0;
    int   n_fail = 0;
    logic done = 1'b0;
    logic phs;
    int   hlen;
    logic [8:0] exp_prev;

    always #4 clk = ~clk;

    flash_backend uut (
        .clk      (clk),
        .rst      (rst),
        .half_sel (half_sel),
        .cnv_clk  (cnv_clk),
        .thermo_i (thermo_i),
        .oe_all_n (oe_all_n),
        .oe_data  (oe_data),
        .data_o   (data_o),
        .ovf_o    (ovf_o)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [8:0] expect_of(input logic [NC-1:0] v);
        return {v[NC-1], 8'($countones(v[NC-2:0]))};
    endfunction

    function automatic logic [NC-1:0] therm(input int p);
        if (p >= NC) return '1;
        return (NC'(1) << p) - NC'(1);
    endfunction

    // Reset with the sample level present, then a sample-level prelude (R9)
    task automatic do_reset(input logic p, input int h);
        @(negedge clk);
        phs = p; hlen = h;
        rst = 1'b1; half_sel = p; cnv_clk = p; thermo_i = '1;
        oe_all_n = 1'b0; oe_data = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 reset", {ovf_o, data_o}, 9'h000);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        cnv_clk = !p;
        repeat (2) @(negedge clk);
        chk("R9 idle", {ovf_o, data_o}, 9'h000);
        exp_prev = 9'h000;
    endtask

    // One converter period: sample half with v, then balance half
    task automatic step(input logic [NC-1:0] v, input string req);
        @(negedge clk);
        cnv_clk = phs;
        thermo_i = v;
        repeat (hlen - 1) @(negedge clk);
        @(negedge clk);
        cnv_clk = !phs;
        @(negedge clk);
        chk(req, {ovf_o, data_o}, exp_prev);
        thermo_i = ~v;
        for (int i = 0; i < hlen - 1; i++) begin
            @(negedge clk);
            chk("R10 hold", {ovf_o, data_o}, exp_prev);
        end
        exp_prev = expect_of(v);
    endtask

    task automatic enable_checks();
        #1;
        oe_all_n = 1'b1; oe_data = 1'b1; #1;
        chk("R7 all off", {ovf_o, data_o}, 9'bz_zzzz_zzzz);
        oe_data = 1'b0; #1;
        chk("R7 all off b", {ovf_o, data_o}, 9'bz_zzzz_zzzz);
        oe_all_n = 1'b0; #1;
        chk("R8 code off", {ovf_o, data_o}, {exp_prev[8], 8'bzzzz_zzzz});
        oe_data = 1'b1; #1;
        chk("R8 restore", {ovf_o, data_o}, exp_prev);
    endtask

    task automatic run_config(input logic p, input int h, input int stride);
        logic [NC-1:0] v;
        string tag;
        do_reset(p, h);
        tag = p ? "R2 R4" : "R4";
        for (int k = 0; k <= NC; k += stride) begin
            if (k == 0 || k == NC) step(therm(k), {tag, " R6 edge"});
            else                   step(therm(k), {tag, " R5 code"});
        end
        step(therm(NC), {tag, " R6 top"});
        for (int k = 10; k < 245; k += 12) begin
            v = therm(k);
            v[k-3] = 1'b0;
            v[k+5] = 1'b1;
            step(v, {tag, " R5 bubble"});
        end
        v = '0;
        v[NC-1] = 1'b1;
        step(v, {tag, " R1 ovf only"});
        step('0, {tag, " R1 top bit"});
        step('0, {tag, " R3 ignore"});
        enable_checks();
    endtask

    initial begin
        run_config(1'b0, 1, 1);
        run_config(1'b1, 2, 1);
        run_config(1'b0, 3, 7);
        run_config(1'b1, 1, 9);
        run_config(1'b1, 3, 13);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule